// File: doc/BRIEF.md
# Buffered Parallel-to-Serial Shift Register

This block turns a byte into a serial bit stream through two register stages. A storage stage samples the parallel data bus when its capture strobe rises. A shift stage can then be loaded from that storage stage and shifted out one bit per rise of its own shift strobe. The capture strobe and the shift strobe are treated as two independent clocks. The stored byte can therefore be refilled while the previous byte is still leaving the shift stage.

Both strobes are ordinary inputs sampled on one system clock, and their rising edges are found inside the block, so the whole design is synchronous. The load request and the clear request are level inputs. While a request is held low it acts on every system clock, whether or not the shift strobe moves. Clearing affects the shift stage only, so a byte that was already captured can still be loaded after a clear.

Top module: `stage_shift_reg`

## Requirements
- R1: After system reset, `ser_out` is 0 and the storage stage holds all zeros, so a load performed before any capture shifts out 0x00.
- R2: The storage stage takes `par_in` only on a 0-to-1 transition of `cap_strobe`. Holding `cap_strobe` high for further cycles captures nothing more, even if `par_in` changes.
- R3: While `load_n` is 0 and `clr_n` is 1, the shift stage takes the stored byte at the next system clock, with no shift strobe needed. `ser_out` then shows bit 7 of that byte.
- R4: On a 0-to-1 transition of `sh_strobe` while `load_n` and `clr_n` are both 1, `ser_in` enters stage 0 and every stage moves one place toward stage WIDTH-1. `ser_out` is stage WIDTH-1. A loaded byte therefore leaves most-significant bit first, one new bit after each shift.
- R5: Holding `sh_strobe` high over several system clocks produces exactly one shift.
- R6: While `clr_n` is 0, the shift stage is cleared to all zeros at every system clock. This clear takes priority over `load_n`.
- R7: `clr_n` does not change the storage stage. A load after a clear shifts out the byte captured before the clear.
- R8: A rise of `sh_strobe` while `load_n` is 0 causes no shift. The loaded byte is shifted out intact afterwards.
- R9: If a capture edge and an active load happen in the same system cycle, the shift stage receives the `par_in` value being captured in that cycle.
- R10: A byte shifted in on `ser_in`, most-significant bit first, over WIDTH shifts appears on `ser_out` in the same order over the following shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset, clears both stages |
| cap_strobe | input | 1 | Storage capture strobe, acts on its rising edge |
| par_in | input | WIDTH | Parallel data bus sampled by the storage stage |
| sh_strobe | input | 1 | Shift strobe, acts on its rising edge |
| ser_in | input | 1 | Serial data that enters stage 0 on each shift |
| load_n | input | 1 | Active-low level request to copy storage into the shift stage |
| clr_n | input | 1 | Active-low level clear of the shift stage only |
| ser_out | output | 1 | Last stage of the shift register |

## Verification
The bench targets the strobes held high over several cycles. A design that acted on strobe levels instead of edges would capture a later bus value, or would shift twice and show the wrong bit on `ser_out`. It also checks the conflicts between requests. A clear placed above a load must leave zeros, and a clear that also wiped storage would lose the byte captured earlier. A shift edge during a load must be ignored, or the byte comes out short by one bit. When a capture and a load happen in the same cycle, a design that copied the old stored byte would show the wrong most-significant bit. A serial loop-through test confirms the shift direction and the bit order.

// File: rtl/stage_shift_pkg.sv
package stage_shift_pkg;

    // operation applied to the shift stage in one system cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_SHIFT = 2'd3
    } chain_op_e;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = strobe & ~st_q.prev;

endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.data;

endmodule

// File: rtl/shift_chain.sv
module shift_chain
    import stage_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chain_op_e        op,
    input  logic [WIDTH-1:0] load_val,
    input  logic             ser_in,
    output logic [1:0]       tail
);

    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_state_t;

    chain_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.bits = '0;
            OP_LOAD:  st_d.bits = load_val;
            OP_SHIFT: st_d.bits = {st_q.bits[LAST-1:0], ser_in};
            default:  st_d.bits = st_q.bits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail = st_q.bits[LAST -: 2];

endmodule

// File: rtl/stage_shift_reg.sv
module stage_shift_reg
    import stage_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_strobe,
    input  logic [WIDTH-1:0] par_in,
    input  logic             sh_strobe,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic             clr_n,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    logic             cap_rise;
    logic             sh_rise;
    logic [WIDTH-1:0] store_bits;
    logic [WIDTH-1:0] load_src;
    logic [1:0]       chain_tail;
    chain_op_e        op;

    strobe_edge u_cap_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_strobe),
        .rise   (cap_rise)
    );

    strobe_edge u_sh_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (sh_strobe),
        .rise   (sh_rise)
    );

    byte_store #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_rise),
        .din     (par_in),
        .dout    (store_bits)
    );

    // a capture in the same cycle as a load forwards the fresh byte
    always_comb begin
        load_src = cap_rise ? par_in : store_bits;
    end

    // priority: clear, then load, then shift
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (sh_rise) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (load_src),
        .ser_in   (ser_in),
        .tail     (chain_tail)
    );

    assign ser_out = chain_tail[1];

    logic unused_ok;
    assign unused_ok = ^{store_bits[LAST], chain_tail[0]} | 1'b0;

endmodule

// File: rtl/stage_shift_reg_chk.sv
module stage_shift_reg_chk (
    input logic clk,
    input logic rst_n,
    input logic clr_n,
    input logic load_n,
    input logic cap_rise,
    input logic sh_rise,
    input logic par_msb,
    input logic store_msb,
    input logic next_bit,
    input logic ser_out
);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !ser_out);

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n && !cap_rise) |=> (ser_out == $past(store_msb)));

    p_fresh_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n && cap_rise) |=> (ser_out == $past(par_msb)));

    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && sh_rise) |=> (ser_out == $past(next_bit)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && !sh_rise) |=> $stable(ser_out));

    p_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rise |=> $stable(store_msb));

endmodule

bind stage_shift_reg stage_shift_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cap_rise  (cap_rise),
    .sh_rise   (sh_rise),
    .par_msb   (par_in[LAST]),
    .store_msb (store_bits[LAST]),
    .next_bit  (chain_tail[0]),
    .ser_out   (ser_out)
);

// File: tb/stage_shift_reg_test.sv
`timescale 1ns/1ps
module stage_shift_reg_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_strobe = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         sh_strobe = 1'b0;
    logic         ser_in = 1'b0;
    logic         load_n = 1'b1;
    logic         clr_n = 1'b1;
    logic         ser_out;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    stage_shift_reg #(.WIDTH(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_strobe (cap_strobe),
        .par_in     (par_in),
        .sh_strobe  (sh_strobe),
        .ser_in     (ser_in),
        .load_n     (load_n),
        .clr_n      (clr_n),
        .ser_out    (ser_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic capture(logic [W-1:0] v);
        par_in = v; cap_strobe = 1'b1; tick();
        cap_strobe = 1'b0; tick();
    endtask

    task automatic load();
        load_n = 1'b0; tick();
        load_n = 1'b1;
    endtask

    task automatic shift_one(logic b);
        ser_in = b; sh_strobe = 1'b1; tick();
        sh_strobe = 1'b0; tick();
    endtask

    // ser_out already shows the MSB; shift W-1 times to collect the rest
    task automatic collect(output logic [W-1:0] v);
        v[W-1] = ser_out;
        for (int i = W - 2; i >= 0; i--) begin
            shift_one(1'b0);
            v[i] = ser_out;
        end
    endtask

    task automatic t_reset();
        logic [W-1:0] got;
        check("R1 ser_out after reset", {7'd0, ser_out}, 8'h00);
        load();
        collect(got);
        check("R1 storage cleared by reset", got, 8'h00);
    endtask

    task automatic t_basic();
        logic [W-1:0] got;
        capture(8'hA5);
        load();
        check("R3 msb right after load", {7'd0, ser_out}, 8'h01);
        collect(got);
        check("R4 byte out msb first", got, 8'hA5);
        capture(8'h3C);
        load();
        collect(got);
        check("R2 R4 second byte", got, 8'h3C);
    endtask

    task automatic t_held_cap();
        logic [W-1:0] got;
        par_in = 8'h5A; cap_strobe = 1'b1; tick();
        par_in = 8'hFF; tick(); tick();
        cap_strobe = 1'b0; tick();
        load();
        collect(got);
        check("R2 held capture strobe", got, 8'h5A);
    endtask

    task automatic t_held_shift();
        capture(8'hA5);
        load();
        sh_strobe = 1'b1; tick(); tick(); tick(); tick();
        sh_strobe = 1'b0; tick();
        check("R5 single shift while held", {7'd0, ser_out}, 8'h00);
        shift_one(1'b0);
        check("R5 next shift bit5", {7'd0, ser_out}, 8'h01);
    endtask

    task automatic t_load_beats_shift();
        logic [W-1:0] got;
        capture(8'hC3);
        load_n = 1'b0; sh_strobe = 1'b1; tick();
        load_n = 1'b1; tick();
        sh_strobe = 1'b0; tick();
        collect(got);
        check("R8 shift edge during load ignored", got, 8'hC3);
    endtask

    task automatic t_clear();
        logic [W-1:0] got;
        capture(8'hFF);
        load();
        clr_n = 1'b0; tick();
        check("R6 clear empties chain", {7'd0, ser_out}, 8'h00);
        load_n = 1'b0; tick();
        check("R6 clear beats load", {7'd0, ser_out}, 8'h00);
        clr_n = 1'b1; load_n = 1'b1; tick();
        collect(got);
        check("R6 chain all zeros", got, 8'h00);
        load();
        collect(got);
        check("R7 storage survives clear", got, 8'hFF);
    endtask

    task automatic t_same_cycle();
        logic [W-1:0] got;
        capture(8'h11);
        par_in = 8'hE7; cap_strobe = 1'b1; load_n = 1'b0; tick();
        cap_strobe = 1'b0; load_n = 1'b1;
        check("R9 fresh msb on same-cycle load", {7'd0, ser_out}, 8'h01);
        tick();
        collect(got);
        check("R9 fresh byte loaded", got, 8'hE7);
    endtask

    task automatic t_serial();
        logic [W-1:0] got;
        logic [W-1:0] pat = 8'hB2;
        capture(8'h00);
        load();
        for (int i = W - 1; i >= 0; i--) begin
            shift_one(pat[i]);
        end
        collect(got);
        check("R10 serial loop-through", got, pat);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_held_cap();
        t_held_shift();
        t_load_beats_shift();
        t_clear();
        t_same_cycle();
        t_serial();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule